// File: doc/BRIEF.md
# SMBus Indexed Block Configuration Slave

This block is a synchronous SMBus target that gives a host controller access to a small bank of byte-wide configuration registers. Every write transfer names a starting register index and a byte count, then carries that many data bytes. A read transfer sets the index with a short write phase, turns the bus around with a repeated START and then streams bytes back. The first byte returned is the content of the read-length register, and the number of register bytes that follow is set by that same register, not by the host.

SCL and SDA enter through a two-flop synchroniser and a small glitch filter. START and STOP conditions are recognised from the filtered lines, and the slave pulls SDA low only through an open-drain enable. The core side receives the control fields of the configuration registers as plain ports and supplies the identification values as constant inputs.

Top module: `smbx_slave`

## Requirements
- R1: After reset the control outputs are: power-down drive 0, stop drive 0, bandwidth select 1, bypass select 1, half-rate select 1, all eight output enables 1, all eight stoppable bits 0, and SDA is released. The read-length register (index 6) resets to 0x07.
- R2: The slave acknowledges the 8-bit address byte 0xDC (write) and 0xDD (read). Any other address byte is not acknowledged, and the rest of that transfer is ignored until the next START or STOP.
- R3: A read returns first the read-length register, then registers starting at the current index, one per byte, with the index advancing after each. Index 0 reads {power-down drive, stop drive, 3'b000, bandwidth, bypass, half-rate} from bit 7 down to bit 0; index 4 reads {revision[3:0], vendor[3:0]}; index 5 reads the device ID.
- R4: A write of index N, count X and X data bytes stores them into registers N to N+X-1 and acknowledges every byte. Index 1 drives the output-enable port and index 2 drives the stoppable port, bit i to bit i.
- R5: At index 0 the bits 5 to 3 are reserved: writes to them are dropped and they read 0.
- R6: Writes to index 3, 4, 5 or any index from 7 upward are acknowledged and discarded; index 3 and indices from 7 upward read 0x00.
- R7: Once the read-length count of register bytes has been returned, further bytes read by the host are all ones (SDA released).
- R8: In a write, a data byte beyond the byte count is not acknowledged and is not stored.
- R9: A STOP or START in the middle of a byte discards that partial byte; bytes completed before it stay written, and a START always begins a new address phase.
- R10: The slave changes its SDA drive only while the filtered SCL is low.
- R11: A control output changes only through a write to the register that holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open drain) |
| rev_id_i | input | 4 | Constant revision identifier |
| vendor_id_i | input | 4 | Constant vendor identifier |
| dev_id_i | input | 8 | Constant device identifier |
| pd_drive_o | output | 1 | Power-down drive mode control |
| stop_drive_o | output | 1 | Stop drive mode control |
| bw_sel_o | output | 1 | Loop bandwidth select control |
| bypass_o | output | 1 | Bypass or locked-loop select control |
| half_rate_o | output | 1 | Divide-by-two select control |
| out_en_o | output | 8 | Per-output enable bits |
| stoppable_o | output | 8 | Per-output stoppable bits |

## Verification
The two functions that can land in the same core cycle are the commit of a just-completed write byte and a bus condition (STOP or repeated START) arriving around it; the design gives the condition priority over any bit-level action. The bench provokes this by finishing one data byte, clocking a few bits of the next and then issuing a STOP, and in a second transfer a repeated START followed by a read address. It judges the outcome at the ports: the completed byte must appear on its output, the interrupted neighbour must keep its old value, and the read that follows the START must be acknowledged and return the read-length byte.

// File: rtl/smbx_pkg.sv
package smbx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_HACK,
        ST_IGNORE
    } bus_st_e;

    typedef enum logic [2:0] {
        STG_ADDR,
        STG_INDEX,
        STG_COUNT,
        STG_WDATA,
        STG_RCOUNT,
        STG_RDATA
    } stage_e;

    localparam logic [7:0] IDX_MODE  = 8'd0;
    localparam logic [7:0] IDX_OE    = 8'd1;
    localparam logic [7:0] IDX_STOP  = 8'd2;
    localparam logic [7:0] IDX_IDENT = 8'd4;
    localparam logic [7:0] IDX_DEV   = 8'd5;
    localparam logic [7:0] IDX_CNT   = 8'd6;

    localparam logic [1:0] RST_MODE_HI = 2'b00;
    localparam logic [2:0] RST_MODE_LO = 3'b111;
    localparam logic [7:0] RST_OE      = 8'hFF;
    localparam logic [7:0] RST_STOP    = 8'h00;
    localparam logic [7:0] RST_CNT     = 8'h07;

    typedef struct packed {
        logic [1:0] mode_hi;
        logic [2:0] mode_lo;
        logic [7:0] oe;
        logic [7:0] stp;
        logic [7:0] cnt;
    } regs_t;

    typedef struct packed {
        bus_st_e    st;
        stage_e     stg;
        logic [7:0] sh;
        logic [3:0] bitc;
        logic       oe;
        logic [7:0] idx;
        logic [7:0] rem;
        logic       scl_p;
        logic       sda_p;
    } ctl_t;

endpackage

// File: rtl/smbx_filt.sv
module smbx_filt #(
    parameter int STAGES   = 2,
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [STAGES-1:0] sync_q, sync_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic              filt_q, filt_d;
    logic              raw;

    assign raw = sync_q[STAGES-1];

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], d_i};
        cnt_d  = '0;
        filt_d = filt_q;
        if (raw != filt_q) begin
            if (cnt_q == CW'(FILT_LEN - 1)) begin
                filt_d = raw;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            cnt_q  <= cnt_d;
            filt_q <= filt_d;
        end
    end

    assign q_o = filt_q;
endmodule

// File: rtl/smbx_regs.sv
module smbx_regs
    import smbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [7:0] wr_idx_i,
    input  logic [7:0] wr_data_i,
    input  logic [7:0] rd_idx_i,
    output logic [7:0] rd_data_o,
    input  logic [3:0] rev_id_i,
    input  logic [3:0] vendor_id_i,
    input  logic [7:0] dev_id_i,
    output regs_t      regs_o
);
    regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (wr_en_i) begin
            unique case (wr_idx_i)
                IDX_MODE: begin
                    r_d.mode_hi = wr_data_i[7:6];
                    r_d.mode_lo = wr_data_i[2:0];
                end
                IDX_OE:   r_d.oe  = wr_data_i;
                IDX_STOP: r_d.stp = wr_data_i;
                IDX_CNT:  r_d.cnt = wr_data_i;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (rd_idx_i)
            IDX_MODE:  rd_data_o = {r_q.mode_hi, 3'b000, r_q.mode_lo};
            IDX_OE:    rd_data_o = r_q.oe;
            IDX_STOP:  rd_data_o = r_q.stp;
            IDX_IDENT: rd_data_o = {rev_id_i, vendor_id_i};
            IDX_DEV:   rd_data_o = dev_id_i;
            IDX_CNT:   rd_data_o = r_q.cnt;
            default:   rd_data_o = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mode_hi <= RST_MODE_HI;
            r_q.mode_lo <= RST_MODE_LO;
            r_q.oe      <= RST_OE;
            r_q.stp     <= RST_STOP;
            r_q.cnt     <= RST_CNT;
        end else begin
            r_q <= r_d;
        end
    end

    assign regs_o = r_q;
endmodule

// File: rtl/smbx_slave.sv
module smbx_slave
    import smbx_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6E,
    parameter int         SYNC_STG = 2,
    parameter int         FILT_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [3:0] rev_id_i,
    input  logic [3:0] vendor_id_i,
    input  logic [7:0] dev_id_i,
    output logic       pd_drive_o,
    output logic       stop_drive_o,
    output logic       bw_sel_o,
    output logic       bypass_o,
    output logic       half_rate_o,
    output logic [7:0] out_en_o,
    output logic [7:0] stoppable_o
);
    localparam logic [7:0] WR_ADDR = {DEV_ADDR, 1'b0};
    localparam logic [7:0] RD_ADDR = {DEV_ADDR, 1'b1};

    logic       scl_f, sda_f;
    logic       scl_rise, scl_fall, start_ev, stop_ev;
    logic       wr_en;
    logic [7:0] wr_idx, rx_byte, rd_data, next_tx;
    regs_t      regs;
    ctl_t       s_q, s_d;

    smbx_filt #(.STAGES(SYNC_STG), .FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_f)
    );
    smbx_filt #(.STAGES(SYNC_STG), .FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_f)
    );

    smbx_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(rx_byte),
        .rd_idx_i(s_q.idx), .rd_data_o(rd_data),
        .rev_id_i(rev_id_i), .vendor_id_i(vendor_id_i), .dev_id_i(dev_id_i),
        .regs_o(regs)
    );

    assign scl_rise = scl_f & ~s_q.scl_p;
    assign scl_fall = ~scl_f & s_q.scl_p;
    assign start_ev = scl_f & s_q.scl_p & s_q.sda_p & ~sda_f;
    assign stop_ev  = scl_f & s_q.scl_p & ~s_q.sda_p & sda_f;
    assign rx_byte  = {s_q.sh[6:0], sda_f};
    assign wr_idx   = s_q.idx;
    assign next_tx  = (s_q.rem != 8'd0) ? rd_data : 8'hFF;

    always_comb begin
        s_d       = s_q;
        s_d.scl_p = scl_f;
        s_d.sda_p = sda_f;
        wr_en     = 1'b0;
        if (start_ev) begin
            s_d.st   = ST_RX;
            s_d.stg  = STG_ADDR;
            s_d.bitc = 4'd0;
            s_d.oe   = 1'b0;
        end else if (stop_ev) begin
            s_d.st   = ST_IDLE;
            s_d.bitc = 4'd0;
            s_d.oe   = 1'b0;
        end else begin
            unique case (s_q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        s_d.sh   = rx_byte;
                        s_d.bitc = s_q.bitc + 4'd1;
                        if (s_q.bitc == 4'd7) begin
                            unique case (s_q.stg)
                                STG_ADDR: begin
                                    if (rx_byte == WR_ADDR)      s_d.stg = STG_INDEX;
                                    else if (rx_byte == RD_ADDR) s_d.stg = STG_RCOUNT;
                                    else                         s_d.st  = ST_IGNORE;
                                end
                                STG_INDEX: begin
                                    s_d.idx = rx_byte;
                                    s_d.stg = STG_COUNT;
                                end
                                STG_COUNT: begin
                                    s_d.rem = rx_byte;
                                    s_d.stg = STG_WDATA;
                                end
                                STG_WDATA: begin
                                    if (s_q.rem != 8'd0) begin
                                        wr_en   = 1'b1;
                                        s_d.idx = s_q.idx + 8'd1;
                                        s_d.rem = s_q.rem - 8'd1;
                                    end else begin
                                        s_d.st = ST_IGNORE;
                                    end
                                end
                                default: s_d.st = ST_IGNORE;
                            endcase
                        end
                    end else if (scl_fall && s_q.bitc == 4'd8) begin
                        s_d.st = ST_ACK;
                        s_d.oe = 1'b1;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        s_d.bitc = 4'd0;
                        if (s_q.stg == STG_RCOUNT) begin
                            s_d.st  = ST_TX;
                            s_d.stg = STG_RDATA;
                            s_d.sh  = regs.cnt;
                            s_d.rem = regs.cnt;
                            s_d.oe  = ~regs.cnt[7];
                        end else begin
                            s_d.st = ST_RX;
                            s_d.oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (s_q.bitc == 4'd7) begin
                            s_d.st = ST_HACK;
                            s_d.oe = 1'b0;
                        end else begin
                            s_d.bitc = s_q.bitc + 4'd1;
                            s_d.sh   = {s_q.sh[6:0], 1'b0};
                            s_d.oe   = ~s_q.sh[6];
                        end
                    end
                end
                ST_HACK: begin
                    if (scl_rise && sda_f) begin
                        s_d.st = ST_IGNORE;
                    end else if (scl_fall) begin
                        s_d.st   = ST_TX;
                        s_d.bitc = 4'd0;
                        s_d.sh   = next_tx;
                        s_d.oe   = ~next_tx[7];
                        if (s_q.rem != 8'd0) begin
                            s_d.idx = s_q.idx + 8'd1;
                            s_d.rem = s_q.rem - 8'd1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= ST_IDLE;
            s_q.stg   <= STG_ADDR;
            s_q.sh    <= 8'h00;
            s_q.bitc  <= 4'd0;
            s_q.oe    <= 1'b0;
            s_q.idx   <= 8'h00;
            s_q.rem   <= 8'h00;
            s_q.scl_p <= 1'b1;
            s_q.sda_p <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_oe_o     = s_q.oe;
    assign pd_drive_o   = regs.mode_hi[1];
    assign stop_drive_o = regs.mode_hi[0];
    assign bw_sel_o     = regs.mode_lo[2];
    assign bypass_o     = regs.mode_lo[1];
    assign half_rate_o  = regs.mode_lo[0];
    assign out_en_o     = regs.oe;
    assign stoppable_o  = regs.stp;
endmodule

// File: rtl/smbx_slave_chk.sv
module smbx_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       sda_oe,
    input logic       wr_en,
    input logic [7:0] wr_idx,
    input logic [4:0] ctl,
    input logic [7:0] oe_en,
    input logic [7:0] stp_en
);
    // R10
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    // R11
    oe_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == 8'd1) |=> $stable(oe_en));

    // R11
    stop_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == 8'd2) |=> $stable(stp_en));

    // R5
    mode_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == 8'd0) |=> $stable(ctl));

    // R9
    wr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (scl_f && !$past(scl_f)));
endmodule

bind smbx_slave smbx_slave_chk chk_i (
    .clk(clk),
    .rst_n(rst_n),
    .scl_f(scl_f),
    .sda_oe(sda_oe_o),
    .wr_en(wr_en),
    .wr_idx(wr_idx),
    .ctl({pd_drive_o, stop_drive_o, bw_sel_o, bypass_o, half_rate_o}),
    .oe_en(out_en_o),
    .stp_en(stoppable_o)
);

// File: tb/smbx_slave_tb_top.sv
module smbx_slave_tb_top;
    localparam int HT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic       sda_oe;
    logic       pd_d, st_d, bw, byp, half;
    logic [7:0] oe_en, stp_en;
    wire        sda_line = sda_h & ~sda_oe;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] act_q[$];
    logic [7:0] wbuf[8];

    always #2 clk = ~clk;

    smbx_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .rev_id_i(4'h2), .vendor_id_i(4'h1), .dev_id_i(8'h81),
        .pd_drive_o(pd_d), .stop_drive_o(st_d), .bw_sel_o(bw), .bypass_o(byp),
        .half_rate_o(half), .out_en_o(oe_en), .stoppable_o(stp_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; tick(HT);
        scl_h = 1'b1; tick(HT);
        sda_h = 1'b0; tick(HT);
        scl_h = 1'b0; tick(HT);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(HT);
        scl_h = 1'b1; tick(HT);
        sda_h = 1'b1; tick(HT);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_h = b;    tick(HT);
        scl_h = 1'b1; tick(HT / 2);
        s = sda_line; tick(HT / 2);
        scl_h = 1'b0; tick(HT / 2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(nack, s);
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // write transfer: index, count, then n bytes from wbuf; bytes past cnt must be NACKed
    task automatic wr_txn(input logic [7:0] idx, input logic [7:0] cnt, input int n, input string tag);
        logic a;
        bus_start();
        send_byte(8'hDC, a); chk({tag, " R2 write address ack"}, a, 1);
        send_byte(idx, a);   chk({tag, " R4 index ack"}, a, 1);
        send_byte(cnt, a);   chk({tag, " R4 count ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            chk({tag, " R4/R8 data ack"}, a, (i < int'(cnt)) ? 1 : 0);
        end
        bus_stop();
    endtask

    // read transfer: count byte plus n more bytes, last one NACKed
    task automatic rd_txn(input logic [7:0] idx, input int n);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hDC, a); chk("R2 read setup address ack", a, 1);
        send_byte(idx, a);   chk("R3 read index ack", a, 1);
        bus_start();
        send_byte(8'hDD, a); chk("R2 read address ack", a, 1);
        for (int i = 0; i <= n; i++) begin
            recv_byte((i == n) ? 1'b1 : 1'b0, b);
            act_q.push_back(b);
        end
        bus_stop();
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0) begin
                logic [7:0] got;
                got = act_q.pop_front();
                if (exp_q.size() == 0) begin
                    chk("scoreboard unexpected read byte", got, 32'hFFFF_FFFF);
                end else begin
                    chk(tag_q.pop_front(), got, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic a;
        logic s;
        logic [7:0] b;
        tick(5);
        rst_n = 1'b1;
        tick(10);

        // R1 reset state at the ports
        chk("R1 control bits", {pd_d, st_d, bw, byp, half}, 5'b00111);
        chk("R1 output enables", oe_en, 8'hFF);
        chk("R1 stoppable bits", stp_en, 8'h00);
        chk("R1 sda released", sda_oe, 0);

        // R1/R3 default read of all registers
        expect_byte(8'h07, "R1 R3 count byte");
        expect_byte(8'h07, "R3 idx0");
        expect_byte(8'hFF, "R3 idx1");
        expect_byte(8'h00, "R3 idx2");
        expect_byte(8'h00, "R6 idx3");
        expect_byte(8'h21, "R3 idx4 ident");
        expect_byte(8'h81, "R3 idx5 device");
        expect_byte(8'h07, "R1 idx6 count reg");
        rd_txn(8'd0, 7);

        // R4 block write to index 1 and 2
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
        wr_txn(8'd1, 8'd2, 2, "T2");
        chk("R4 output enables", oe_en, 8'hA5);
        chk("R4 stoppable bits", stp_en, 8'h3C);

        // R5 mode register with reserved bits set
        wbuf[0] = 8'hFF;
        wr_txn(8'd0, 8'd1, 1, "T3");
        chk("R5 control bits", {pd_d, st_d, bw, byp, half}, 5'b11111);

        // R6 read-only and reserved indices
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wr_txn(8'd3, 8'd3, 3, "T4");
        wbuf[0] = 8'h55;
        wr_txn(8'd7, 8'd1, 1, "T4b");

        wbuf[0] = 8'h05;
        wr_txn(8'd6, 8'd1, 1, "T5");
        expect_byte(8'h05, "R3 written count byte");
        expect_byte(8'hC7, "R5 idx0 reserved zero");
        expect_byte(8'hA5, "R4 idx1 readback");
        expect_byte(8'h3C, "R4 idx2 readback");
        expect_byte(8'h00, "R6 idx3 stays zero");
        expect_byte(8'h21, "R6 idx4 unchanged");
        rd_txn(8'd0, 5);

        // R7 reading past the count
        wbuf[0] = 8'h02;
        wr_txn(8'd6, 8'd1, 1, "T6");
        expect_byte(8'h02, "R7 count byte");
        expect_byte(8'h81, "R7 idx5");
        expect_byte(8'h02, "R7 idx6");
        expect_byte(8'hFF, "R7 beyond count");
        rd_txn(8'd5, 3);

        // R8 extra data byte beyond count
        wbuf[0] = 8'h66; wbuf[1] = 8'h77;
        wr_txn(8'd2, 8'd1, 2, "T7");
        chk("R8 stoppable written", stp_en, 8'h66);
        chk("R8 extra byte not stored", oe_en, 8'hA5);

        // R2 foreign address ignored
        bus_start();
        send_byte(8'hA0, a); chk("R2 foreign address nack", a, 0);
        send_byte(8'h02, a);
        send_byte(8'h01, a);
        send_byte(8'h00, a);
        bus_stop();
        chk("R2 foreign transfer no effect", stp_en, 8'h66);

        // R9 STOP in the middle of the second data byte
        bus_start();
        send_byte(8'hDC, a);
        send_byte(8'h01, a);
        send_byte(8'h02, a);
        send_byte(8'h0F, a); chk("R9 first data ack", a, 1);
        for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
        bus_stop();
        chk("R9 completed byte kept", oe_en, 8'h0F);
        chk("R9 partial byte dropped", stp_en, 8'h66);

        // R9 START in the middle of a byte begins a new address phase
        bus_start();
        send_byte(8'hDC, a);
        send_byte(8'h02, a);
        send_byte(8'h01, a);
        for (int i = 0; i < 3; i++) clk_bit(1'b0, s);
        bus_start();
        send_byte(8'hDD, a); chk("R9 restart read address ack", a, 1);
        recv_byte(1'b1, b);
        chk("R9 count byte after restart", b, 8'h02);
        bus_stop();
        chk("R9 interrupted write dropped", stp_en, 8'h66);

        tick(20);
        chk("R3 scoreboard drained", exp_q.size(), 0);
        report();
    end
endmodule